// File: doc/BRIEF.md
# Standby Bus Wake-Up Filter with Stuck-Bus Lockout

This block sits on the receive side of a bus transceiver node. While the node is in low-power standby, it watches a digital bus-dominant flag, which comes from an analog comparator outside the block. It drives an active-low receive level back to the protocol controller. A dominant bus period that lasts at least the filter time pulls the receive output low as a wake-up request. Shorter dominant glitches are filtered out and leave the output high.

If standby is entered while the bus already reads dominant, the block assumes a stuck-dominant fault and locks out wake-up reporting. The lockout is lifted only after the bus has stayed recessive for an unbroken clear time. After that, the normal filter applies again. Outside standby, the filter and the lockout are held idle and the receive output passes the main receiver bit straight through.

The controller is an explicit state machine with four states:
- `ST_OFF`: not in standby.
- `ST_ARMED`: filtering, no request.
- `ST_LOCK`: stuck-bus lockout.
- `ST_WAKE`: wake-up request active.

Its transitions are:
- OFF→ARMED: standby entered with the bus recessive.
- OFF→LOCK: standby entered with the bus dominant.
- ARMED→WAKE: the dominant run reaches the filter length.
- WAKE→ARMED: the bus goes recessive.
- LOCK→ARMED: the recessive run reaches the clear length.
- Any state→OFF: standby drops.

Top module: `bus_wake_filter`

## Requirements
- R1: While reset is asserted the state machine sits in ST_OFF, so with the standby flag high the receive output reads 1 (recessive).
- R2: With standby_i low, rx_o equals norm_rx_i in the same cycle, whatever the bus flag does.
- R3: In standby, with the state machine in ST_ARMED, FILT_CYCLES consecutive synchronised dominant samples (bus_dom_i = 1 means dominant) move it to ST_WAKE and drive rx_o to 0.
- R4: In standby, a dominant run of fewer than FILT_CYCLES samples leaves rx_o at 1.
- R5: In ST_WAKE, the first recessive synchronised sample returns the state machine to ST_ARMED and rx_o to 1, and a new request needs a fresh full-length dominant run.
- R6: If the synchronised bus flag is dominant in the cycle standby is entered, the state machine goes to ST_LOCK, and no dominant run of any length drives rx_o low while locked.
- R7: The lockout clears only after CLEAR_CYCLES consecutive recessive samples. A recessive gap one sample shorter, followed by dominant, keeps the lockout.
- R8: After the lockout clears, a dominant run of FILT_CYCLES samples again produces a wake-up request.
- R9: Dropping standby_i returns the state machine to ST_OFF on the next edge and discards all filter and lockout progress.
- R10: bus_dom_i passes through a SYNC_STAGES-flop synchroniser (default 2). A dominant run starting after edge P0 therefore pulls rx_o low after edge P0+FILT_CYCLES+SYNC_STAGES and not one edge earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | High while the node is in low-power standby |
| bus_dom_i | input | 1 | Comparator result, 1 = bus dominant, asynchronous |
| norm_rx_i | input | 1 | Main receiver bit used outside standby |
| rx_o | output | 1 | Receive level, 0 = dominant or wake-up request |

## Verification
The bench aims at the exact filter edges. It sends runs of FILT_CYCLES-1 and FILT_CYCLES samples: an off-by-one counter would either wake on the short run or need one sample more. It checks the wake timing at the edge before and at the edge of the expected change, which catches a missing or extra synchroniser stage. It enters standby on a dominant bus and then offers a recessive gap of CLEAR_CYCLES-1 samples followed by a full gap. A lockout that is ignored, or that clears early, would then show a request where none may appear. Long random runs around both limits, together with standby toggles, are compared cycle by cycle against a bench model. These runs expose counters that fail to restart after a request or after leaving standby.

// File: rtl/wake_filter_pkg.sv
package wake_filter_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_LOCK  = 2'd2,
        ST_WAKE  = 2'd3
    } wf_state_e;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= 1'b0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/run_counter.sv
module run_counter #(
    parameter int LIMIT = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic hit_o
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign hit_o = inc_i && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr_i || hit_o) begin
            cnt <= '0;
        end else if (inc_i) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the run count never passes the last value before the limit
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
    import wake_filter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic dom_i,
    input  logic dom_hit_i,
    input  logic clr_hit_i,
    output logic armed_o,
    output logic lock_o,
    output logic req_n_o
);
    wf_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (standby_i) state_nx = dom_i ? ST_LOCK : ST_ARMED;
            ST_ARMED: if (dom_hit_i) state_nx = ST_WAKE;
            ST_LOCK:  if (clr_hit_i) state_nx = ST_ARMED;
            ST_WAKE:  if (!dom_i)    state_nx = ST_ARMED;
        endcase
        if (!standby_i) state_nx = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        armed_o = 1'b0;
        lock_o  = 1'b0;
        req_n_o = 1'b1;
        unique case (state)
            ST_OFF:   ;
            ST_ARMED: armed_o = 1'b1;
            ST_LOCK:  lock_o  = 1'b1;
            ST_WAKE:  req_n_o = 1'b0;
        endcase
    end

    // R3: a request is only ever held after a dominant sample
    a_r3_wake_on_dom: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |-> $past(dom_i));
    // R6: entering standby on a dominant bus arms the lockout
    a_r6_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && standby_i && dom_i) |=> (state == ST_LOCK));
    // R7: the lockout never turns straight into a request
    a_r7_lock_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK) |=> (state != ST_WAKE));
    // R5: a recessive sample ends the request
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && standby_i && !dom_i) |=> (state == ST_ARMED));
    // R9: leaving standby idles the machine
    a_r9_leave_off: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_i |=> (state == ST_OFF));
endmodule

// File: rtl/bus_wake_filter.sv
module bus_wake_filter #(
    parameter int FILT_CYCLES  = 400,
    parameter int CLEAR_CYCLES = 320,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic bus_dom_i,
    input  logic norm_rx_i,
    output logic rx_o
);
    logic dom_s;
    logic armed, lock, req_n;
    logic dom_hit, clr_hit;
    logic dom_inc, rec_inc;

    bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(bus_dom_i), .q_o(dom_s)
    );

    assign dom_inc = armed && dom_s;
    assign rec_inc = lock && !dom_s;

    run_counter #(.LIMIT(FILT_CYCLES)) u_dom_run (
        .clk(clk), .rst_n(rst_n), .clr_i(!dom_inc), .inc_i(dom_inc), .hit_o(dom_hit)
    );

    run_counter #(.LIMIT(CLEAR_CYCLES)) u_rec_run (
        .clk(clk), .rst_n(rst_n), .clr_i(!rec_inc), .inc_i(rec_inc), .hit_o(clr_hit)
    );

    wake_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .dom_i(dom_s),
        .dom_hit_i(dom_hit), .clr_hit_i(clr_hit),
        .armed_o(armed), .lock_o(lock), .req_n_o(req_n)
    );

    assign rx_o = standby_i ? req_n : norm_rx_i;

    // R6: while locked out the receive output stays recessive in standby
    a_r6_locked_high: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && standby_i) |-> rx_o);
endmodule

// File: tb/bus_wake_filter_bench.sv
module bus_wake_filter_bench;
    localparam int L = 400;
    localparam int C = 320;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby = 1'b0;
    logic bus_dom = 1'b0;
    logic norm_rx = 1'b1;
    logic rx;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_wake_filter #(.FILT_CYCLES(L), .CLEAR_CYCLES(C), .SYNC_STAGES(2)) u_bus_wake_filter (
        .clk(clk), .rst_n(rst_n), .standby_i(standby), .bus_dom_i(bus_dom),
        .norm_rx_i(norm_rx), .rx_o(rx)
    );

    // Reference model built from the requirements
    bit m_s1, m_s2, m_insb, m_lock, m_wake;
    int m_drun, m_rrun;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_insb = 0; m_lock = 0; m_wake = 0;
            m_drun = 0; m_rrun = 0;
        end else begin
            bit d;
            d = m_s2;
            if (!standby) begin
                m_insb = 0; m_lock = 0; m_wake = 0; m_drun = 0; m_rrun = 0;
            end else if (!m_insb) begin
                m_insb = 1; m_lock = d; m_wake = 0; m_drun = 0; m_rrun = 0;
            end else if (m_lock) begin
                m_rrun = d ? 0 : m_rrun + 1;
                if (m_rrun == C) begin m_lock = 0; m_rrun = 0; end
            end else if (m_wake) begin
                if (!d) m_wake = 0;
            end else begin
                m_drun = d ? m_drun + 1 : 0;
                if (m_drun == L) begin m_wake = 1; m_drun = 0; end
            end
            m_s2 = m_s1;
            m_s1 = bus_dom;
        end
    end

    function automatic bit exp_rx();
        return standby ? !m_wake : norm_rx;
    endfunction

    function automatic string ctx_tag();
        if (!standby) return "R2";
        if (m_lock) return "R6";
        if (m_wake) return "R3";
        return "R4";
    endfunction

    task automatic check(input bit got, input bit exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: rx_o=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (mon_en && rst_n) check(rx, exp_rx(), ctx_tag());
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state with standby high reads recessive
        standby = 1; norm_rx = 0;
        #1 check(rx, 1'b1, "R1");
        tick(3);
        check(rx, 1'b1, "R1");
        standby = 0;
        tick(1);
        rst_n = 1;
        tick(2);
        mon_en = 1;

        // R2: passthrough outside standby, bus flag irrelevant
        for (int i = 0; i < 20; i++) begin
            norm_rx = i[0];
            bus_dom = i[1];
            #0.5 check(rx, i[0], "R2");
            tick(1);
        end
        bus_dom = 0; norm_rx = 1;
        tick(4);

        standby = 1;
        tick(5);
        // R4: one sample short of the filter
        bus_dom = 1; tick(L - 1);
        bus_dom = 0; tick(L + 5);
        check(rx, 1'b1, "R4");

        // R10 / R3: exact wake edge
        bus_dom = 1;
        tick(L + 1);
        check(rx, 1'b1, "R10");
        tick(1);
        check(rx, 1'b0, "R3");
        tick(50);
        check(rx, 1'b0, "R3");
        // R5: release after synchroniser plus one edge
        bus_dom = 0;
        tick(2);
        check(rx, 1'b0, "R5");
        tick(1);
        check(rx, 1'b1, "R5");
        tick(10);

        // R9: wake, leave standby, progress discarded
        bus_dom = 1;
        tick(L + 2);
        check(rx, 1'b0, "R3");
        standby = 0; norm_rx = 1;
        #0.5 check(rx, 1'b1, "R9");
        tick(3);
        check(rx, 1'b1, "R9");

        // R6: enter standby while dominant -> locked
        standby = 1;
        tick(2 * L);
        check(rx, 1'b1, "R6");

        // R7: gap one short of clear keeps lockout
        bus_dom = 0; tick(C - 1);
        bus_dom = 1; tick(L + 10);
        check(rx, 1'b1, "R7");

        // R7 / R8: full gap clears, then a full dominant run wakes
        bus_dom = 0; tick(C);
        bus_dom = 1;
        tick(L + 1);
        check(rx, 1'b1, "R8");
        tick(1);
        check(rx, 1'b0, "R8");
        bus_dom = 0;
        tick(10);
        check(rx, 1'b1, "R7");

        // Random runs around both limits
        for (int r = 0; r < 120; r++) begin
            int len;
            int pick;
            pick = int'($urandom_range(0, 9));
            if (pick == 0) begin
                standby = ~standby;
                len = int'($urandom_range(1, 6));
            end else begin
                bus_dom = ~bus_dom;
                if (pick < 4)      len = int'($urandom_range(1, 20));
                else if (pick < 6) len = L - 2 + int'($urandom_range(0, 4));
                else if (pick < 8) len = C - 2 + int'($urandom_range(0, 4));
                else               len = int'($urandom_range(1, 2 * L));
            end
            for (int k = 0; k < len; k++) begin
                norm_rx = 1'($urandom_range(0, 1));
                tick(1);
            end
        end
        mon_en = 0;
        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule